// File: doc/BRIEF.md
# Page Write Buffer with Protection

This block sits behind a byte-level serial slave front end and turns received write traffic into page programming of a 512-byte memory. The memory is split into 32 pages of 16 bytes. A write transfer opens with a start pulse carrying a 9-bit address. The upper five bits pick the page and the lower four bits pick the first byte slot. Each data byte that follows goes into a 16-entry page buffer. The slot index moves forward by one after every byte and wraps inside the page.

When the bus STOP arrives, the block checks whether the commit is allowed. If it is, a self-timed programming period starts. During that period `busy` is high, all new traffic is ignored, and the buffered bytes land in memory on the final cycle. A commit is refused in three cases: the global write-protect input is high, the page's own protection bit is set, or the transfer carried no data. A refused commit leaves memory untouched and never raises `busy`.

A side port sets or clears the protection bit of a page. A combinational read port returns a stored byte and the protection bit of the page that holds it. The programming time is a parameter counted in clock cycles. The serial protocol, charge pump and non-volatile cells are modelled elsewhere or not at all.

Top module: `pwb_top`

## Requirements
- R1: After reset `busy` is 0, every memory byte reads 8'hFF and every page protection bit reads 0.
- R2: Bytes received after a start pulse go to consecutive slots of the addressed page, beginning at slot `wrAddr[3:0]`. At an accepted STOP they are committed. Slots that received no byte keep their old contents.
- R3: The slot index wraps from 15 to 0 inside the same page. A later byte aimed at a slot already filled replaces the earlier one. No other page changes.
- R4: An accepted STOP raises `busy` on the next clock edge. `busy` then stays high for exactly PROG_CYCLES cycles. Memory contents are unchanged while `busy` is high and show the new bytes once `busy` falls.
- R5: While `busy` is high, `wrStart`, `byteValid`, `stopIn` and `protWr` have no effect.
- R6: If `wpIn` is high when STOP arrives, memory is unchanged and `busy` stays 0.
- R7: If the protection bit of the addressed page is 1 when STOP arrives, memory is unchanged and `busy` stays 0. Unprotected pages remain writable.
- R8: `protWr` loads `protVal` into the protection bit of page `protPage` only when `wpIn` is low. When `wpIn` is high the pulse is ignored.
- R9: A STOP with no data byte since the start pulse changes nothing and does not raise `busy`.
- R10: A start pulse arriving during a transfer discards the bytes collected so far and begins a new transfer at the new address.
- R11: `rdData` is the byte stored at `rdAddr`. `rdProt` is the protection bit of page `rdAddr[8:4]`. Both follow `rdAddr` without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStart | input | 1 | Pulse opening a write transfer |
| wrAddr | input | 9 | Page (bits 8:4) and first slot (bits 3:0) of the transfer |
| byteValid | input | 1 | One received data byte is on byteIn |
| byteIn | input | 8 | Received data byte |
| stopIn | input | 1 | Pulse marking the bus STOP condition |
| wpIn | input | 1 | Global write protect, high blocks all changes |
| protWr | input | 1 | Pulse writing one page protection bit |
| protPage | input | 5 | Page whose protection bit is written |
| protVal | input | 1 | New protection bit value |
| rdAddr | input | 9 | Read address |
| rdData | output | 8 | Byte stored at rdAddr |
| rdProt | output | 1 | Protection bit of the page holding rdAddr |
| busy | output | 1 | Programming period in progress |

## Verification
The assertions assume that `wrStart`, `byteValid` and `stopIn` are single-cycle pulses. They also assume that `stopIn` never shares a cycle with a data byte or a start pulse. The bench drives each of these pulses in its own cycle to stay inside that assumption. The assertions also rely on `wpIn` staying steady around each STOP. The bench only changes `wpIn` between transfers, never inside one.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef struct packed {
    logic openXfer;    // start a new transfer, latch page and slot
    logic storeByte;   // write byteIn into the current buffer slot
    logic commit;      // last programming cycle: copy buffer into memory
    logic protUpdate;  // load one page protection bit
  } pwbStrobe_t;
endpackage

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int PROG_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStart,
  input  logic       byteValid,
  input  logic       stopIn,
  input  logic       wpIn,
  input  logic       protWr,
  input  logic       commitOk,
  output pwbStrobe_t strobe,
  output logic       busy
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_COLLECT, S_PROGRAM} state_t;

  state_t           state;
  logic [CNT_W-1:0] progCnt;

  always_comb begin
    strobe.openXfer   = wrStart && (state != S_PROGRAM);
    strobe.storeByte  = byteValid && !wrStart && (state == S_COLLECT);
    strobe.commit     = (state == S_PROGRAM) && (progCnt == '0);
    strobe.protUpdate = protWr && !wpIn && (state != S_PROGRAM);
  end

  assign busy = (state == S_PROGRAM);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      progCnt <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (wrStart) state <= S_COLLECT;
        end
        S_COLLECT: begin
          if (wrStart) begin
            state <= S_COLLECT;
          end else if (stopIn) begin
            if (commitOk && !wpIn) begin
              state   <= S_PROGRAM;
              progCnt <= CNT_W'(PROG_CYCLES - 1);
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_PROGRAM: begin
          if (progCnt == '0) state <= S_IDLE;
          else               progCnt <= progCnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwb_datapath.sv
module pwb_datapath
  import pwb_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  pwbStrobe_t                          strobe,
  input  logic [ADDR_W-1:0]                   wrAddr,
  input  logic [7:0]                          byteIn,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] protPage,
  input  logic                                protVal,
  input  logic [ADDR_W-1:0]                   rdAddr,
  output logic [7:0]                          rdData,
  output logic [(1<<(ADDR_W-$clog2(PAGE_BYTES)))-1:0] protState,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] pageSel,
  output logic                                anyByte
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int PAGES  = 1 << PAGE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [OFF_W-1:0]      slotIdx;
  logic [PAGE_BYTES-1:0] slotFull;
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [7:0]            memArr  [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageSel <= '0;
      slotIdx <= '0;
    end else if (strobe.openXfer) begin
      pageSel <= wrAddr[ADDR_W-1:OFF_W];
      slotIdx <= wrAddr[OFF_W-1:0];
    end else if (strobe.storeByte) begin
      slotIdx <= slotIdx + 1'b1;  // wraps inside the page
    end
  end

  for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
    wire hit = strobe.storeByte && (slotIdx == OFF_W'(s));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotFull[s] <= 1'b0;
        pageBuf[s]  <= '0;
      end else if (strobe.openXfer) begin
        slotFull[s] <= 1'b0;
      end else if (hit) begin
        slotFull[s] <= 1'b1;
        pageBuf[s]  <= byteIn;
      end
    end
  end

  assign anyByte = |slotFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++) memArr[a] <= 8'hFF;
    end else if (strobe.commit) begin
      for (int s = 0; s < PAGE_BYTES; s++)
        if (slotFull[s]) memArr[{pageSel, OFF_W'(s)}] <= pageBuf[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  protState <= '0;
    else if (strobe.protUpdate) protState[protPage] <= protVal;
  end

  assign rdData = memArr[rdAddr];

  initial if (PAGES < 2) $error("page count too small");
endmodule

// File: rtl/pwb_top.sv
module pwb_top
  import pwb_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 500000
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 wrStart,
  input  logic [ADDR_W-1:0]                    wrAddr,
  input  logic                                 byteValid,
  input  logic [7:0]                           byteIn,
  input  logic                                 stopIn,
  input  logic                                 wpIn,
  input  logic                                 protWr,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] protPage,
  input  logic                                 protVal,
  input  logic [ADDR_W-1:0]                    rdAddr,
  output logic [7:0]                           rdData,
  output logic                                 rdProt,
  output logic                                 busy
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int PAGES  = 1 << PAGE_W;

  pwbStrobe_t        strobe;
  logic [PAGES-1:0]  protState;
  logic [PAGE_W-1:0] pageSel;
  logic              anyByte;
  logic              commitOk;

  assign commitOk = anyByte && !protState[pageSel];
  assign rdProt   = protState[rdAddr[ADDR_W-1:OFF_W]];

  pwb_ctrl #(.PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrStart(wrStart), .byteValid(byteValid),
    .stopIn(stopIn), .wpIn(wpIn), .protWr(protWr), .commitOk(commitOk),
    .strobe(strobe), .busy(busy)
  );

  pwb_datapath #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr), .byteIn(byteIn),
    .protPage(protPage), .protVal(protVal), .rdAddr(rdAddr), .rdData(rdData),
    .protState(protState), .pageSel(pageSel), .anyByte(anyByte)
  );
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int PROG_CYCLES = 500000,
  parameter int PAGE_W      = 5,
  parameter int PAGES       = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              stopIn,
  input logic              wpIn,
  input logic              busy,
  input logic [PAGES-1:0]  protState,
  input logic [PAGE_W-1:0] pageSel
);
  localparam int LEN_W = $clog2(PROG_CYCLES + 1);

  logic [LEN_W-1:0] busyLen;
  always_ff @(posedge clk) begin
    if (!rstN)     busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else           busyLen <= '0;
  end

  // R4: busy only rises after a STOP seen with write protect low
  a_r4_rise_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(stopIn) && !$past(wpIn)));

  // R4: the busy window never exceeds the programming length
  a_r4_window_bound: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyLen < LEN_W'(PROG_CYCLES)));

  // R4: the busy window is exactly the programming length
  a_r4_window_exact: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(busyLen) == LEN_W'(PROG_CYCLES - 1)));

  // R6: STOP under write protect never starts programming
  a_r6_wp_no_busy: assert property (@(posedge clk) disable iff (!rstN)
    (stopIn && wpIn && !busy) |=> !busy);

  // R7: STOP aimed at a protected page never starts programming
  a_r7_page_no_busy: assert property (@(posedge clk) disable iff (!rstN)
    (stopIn && !busy && protState[pageSel]) |=> !busy);

  // R8: protection bits frozen while write protect is high
  a_r8_wp_freezes_prot: assert property (@(posedge clk) disable iff (!rstN)
    wpIn |=> $stable(protState));

  // R5: protection bits frozen while programming
  a_r5_busy_freezes_prot: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(protState));
endmodule

bind pwb_top pwb_checker #(.PROG_CYCLES(PROG_CYCLES), .PAGE_W(PAGE_W), .PAGES(PAGES)) chk (
  .clk(clk), .rstN(rstN), .stopIn(stopIn), .wpIn(wpIn), .busy(busy),
  .protState(protState), .pageSel(pageSel)
);

// File: tb/pwb_top_test.sv
module pwb_top_test;
  localparam int P = 20;

  typedef struct packed {
    logic [8:0] addr;
    logic [4:0] cnt;
    logic       wp;
    logic [7:0] seed;
  } vec_t;

  // R2 start offsets, R3 wrap and overwrite, R6 protect, R9 empty transfer
  localparam vec_t VECS [7] = '{
    '{9'h000, 5'd1,  1'b0, 8'h11},
    '{9'h013, 5'd4,  1'b0, 8'h20},
    '{9'h0FC, 5'd6,  1'b0, 8'h40},
    '{9'h1F0, 5'd16, 1'b0, 8'h60},
    '{9'h025, 5'd20, 1'b0, 8'h80},
    '{9'h033, 5'd3,  1'b1, 8'h90},
    '{9'h047, 5'd0,  1'b0, 8'h00}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN = 1'b0, wrStart = 1'b0, byteValid = 1'b0, stopIn = 1'b0;
  logic       wpIn = 1'b0, protWr = 1'b0, protVal = 1'b0;
  logic [8:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] byteIn = '0;
  logic [4:0] protPage = '0;
  logic [7:0] rdData;
  logic       rdProt, busy;

  pwb_top #(.PROG_CYCLES(P)) uut (
    .clk(clk), .rstN(rstN), .wrStart(wrStart), .wrAddr(wrAddr),
    .byteValid(byteValid), .byteIn(byteIn), .stopIn(stopIn), .wpIn(wpIn),
    .protWr(protWr), .protPage(protPage), .protVal(protVal),
    .rdAddr(rdAddr), .rdData(rdData), .rdProt(rdProt), .busy(busy)
  );

  int   checks = 0, fails = 0;
  bit   ended = 0;
  logic [7:0] expMem [512];
  logic       expProt [32];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // R11: read every slot of a page through the read port
  task automatic checkPage(int page, string req);
    bit ok = 1; int act = 0, exp = 0, where = 0;
    for (int o = 0; o < 16; o++) begin
      rdAddr = 9'(page * 16 + o);
      @(negedge clk);
      if (ok && rdData !== expMem[page * 16 + o]) begin
        ok = 0; act = rdData; exp = expMem[page * 16 + o]; where = page * 16 + o;
      end
    end
    check(ok, req, $sformatf("page %0d byte %0h", page, where), act, exp);
  endtask

  task automatic sendXfer(logic [8:0] addr, int n, logic [7:0] seed);
    @(negedge clk); wrStart = 1; wrAddr = addr;
    @(negedge clk); wrStart = 0;
    for (int i = 0; i < n; i++) begin
      byteValid = 1; byteIn = seed + 8'(i);
      @(negedge clk);
    end
    byteValid = 0;
  endtask

  task automatic pulseStop();
    stopIn = 1;
    @(negedge clk); stopIn = 0;
  endtask

  task automatic runXfer(logic [8:0] addr, int n, logic [7:0] seed, logic wp, string req);
    int page = int'(addr[8:4]);
    bit commit = !wp && !expProt[page] && (n > 0);
    int len = 0;
    rdAddr = addr;
    wpIn = wp;
    sendXfer(addr, n, seed);
    pulseStop();
    check(busy == commit, req, "busy after STOP", int'(busy), int'(commit));
    if (commit) begin
      while (busy && len < 1000) begin
        len++;
        if (len == 2)
          check(rdData == expMem[addr], "R4", "memory during busy", rdData, expMem[addr]);
        @(negedge clk);
      end
      check(len == P, "R4", "busy length", len, P);
      for (int i = 0; i < n; i++)
        expMem[{addr[8:4], 4'(addr[3:0] + 4'(i))}] = seed + 8'(i);
    end else begin
      repeat (3) @(negedge clk);
      check(busy == 0, req, "no busy after blocked STOP", busy, 0);
    end
    wpIn = 0;
    checkPage(page, req);
  endtask

  task automatic setProt(int page, logic val);
    @(negedge clk); protWr = 1; protPage = 5'(page); protVal = val;
    @(negedge clk); protWr = 0;
    if (!wpIn) expProt[page] = val;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int a = 0; a < 512; a++) expMem[a] = 8'hFF;
    for (int p = 0; p < 32; p++) expProt[p] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    check(busy == 0, "R1", "busy after reset", busy, 0);
    rdAddr = 9'h1A7; @(negedge clk);
    check(rdData == 8'hFF, "R1", "erased byte", rdData, 8'hFF);
    check(rdProt == 0, "R1", "protection bit", rdProt, 0);
    checkPage(31, "R1");

    // table of transfers (R2, R3, R4, R6, R9)
    for (int v = 0; v < 7; v++)
      runXfer(VECS[v].addr, int'(VECS[v].cnt), VECS[v].seed, VECS[v].wp,
              $sformatf("R2/R3/R6/R9 vec%0d", v));
    checkPage(0, "R3 neighbour page untouched");

    // R8 protection bit written with wp low, ignored with wp high
    setProt(5, 1);
    rdAddr = 9'h050; @(negedge clk);
    check(rdProt == 1, "R8", "page 5 protected", rdProt, 1);
    wpIn = 1; setProt(6, 1); wpIn = 0;
    rdAddr = 9'h060; @(negedge clk);
    check(rdProt == 0, "R8", "page 6 set ignored under wp", rdProt, 0);
    wpIn = 1; setProt(5, 0); wpIn = 0;
    rdAddr = 9'h050; @(negedge clk);
    check(rdProt == 1, "R8", "page 5 clear ignored under wp", rdProt, 1);

    // R7 protected page blocked, neighbour writable, cleared page writable
    runXfer(9'h052, 3, 8'hA0, 0, "R7 protected");
    runXfer(9'h061, 2, 8'hB0, 0, "R7 open page");
    setProt(5, 0);
    runXfer(9'h052, 3, 8'hA0, 0, "R7 after clear");

    // R5 traffic while busy is ignored
    rdAddr = 9'h0A0;
    sendXfer(9'h0A0, 2, 8'hC0);
    pulseStop();
    check(busy == 1, "R5", "busy started", busy, 1);
    wrStart = 1; wrAddr = 9'h0B0; @(negedge clk); wrStart = 0;
    byteValid = 1; byteIn = 8'h5A; @(negedge clk); byteValid = 0;
    stopIn = 1; @(negedge clk); stopIn = 0;
    protWr = 1; protPage = 5'd7; protVal = 1; @(negedge clk); protWr = 0;
    while (busy) @(negedge clk);
    expMem[9'h0A0] = 8'hC0; expMem[9'h0A1] = 8'hC1;
    repeat (3) @(negedge clk);
    check(busy == 0, "R5", "no second busy", busy, 0);
    rdAddr = 9'h070; @(negedge clk);
    check(rdProt == 0, "R5", "protWr during busy", rdProt, 0);
    checkPage(10, "R5 first commit");
    checkPage(11, "R5 ignored transfer");

    // R10 restart discards earlier bytes
    sendXfer(9'h080, 2, 8'hD0);
    @(negedge clk); wrStart = 1; wrAddr = 9'h094;
    @(negedge clk); wrStart = 0;
    byteValid = 1; byteIn = 8'hE7; @(negedge clk); byteValid = 0;
    pulseStop();
    while (busy) @(negedge clk);
    expMem[9'h094] = 8'hE7;
    checkPage(8, "R10 discarded page");
    checkPage(9, "R10 new page");

    finishRun();
  end
endmodule